// File: doc/BRIEF.md
# Baseline 12-bit Instruction Data-Path Unit

This unit executes the data-processing share of a small microcontroller whose instructions are 12 bits wide. Each cycle it takes one instruction word, the working register W, the value of the file register named by the instruction, and the incoming carry, digit-carry and zero flags. From these it forms an 8-bit result and a write strobe that sends the result either to W or back to the file register. It also forms the next values of the three flags. Byte operations on a file register, single-bit set and clear, and operations with an 8-bit literal are decoded here.

All outputs are registered, so the effect of an instruction presented before a rising clock edge is visible after that edge. The surrounding core owns the register file, the program counter, skipping and the I/O pins. It uses the registered address output to steer the file-register write. Any flag that an instruction does not affect is passed from the flag inputs to the flag outputs unchanged.

Top module: `base12_alu`

## Requirements
- R1: While rst_n is low, result, w_we, f_we, f_addr, c_out, dc_out and z_out are all zero.
- R2: Outputs follow the inputs from the previous rising edge, and f_addr equals the instruction's bits [4:0]. For byte operations, bit 5 (the destination bit) set to 0 raises w_we and set to 1 raises f_we. The two write strobes are never high together.
- R3: Opcode bits [11:6]=000111 adds W and the file value. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set when the 8-bit result is zero.
- R4: Opcode bits [11:6]=000010 computes file minus W. C is 1 when no borrow occurs (file >= W), DC is 1 when the low nibble of the file value is >= the low nibble of W, and Z is updated.
- R5: Opcodes 000101 (AND), 000100 (OR) and 000110 (XOR) combine W with the file value. Opcodes 001001 (complement), 001010 (increment), 000011 (decrement) and 001000 (move) act on the file value alone. All of these update Z only and pass C and DC through.
- R6: Opcode 001101 rotates the file value left through carry and opcode 001100 rotates it right through carry. The bit shifted out becomes C, and DC and Z pass through.
- R7: Opcode 001110 exchanges the two nibbles of the file value. Opcodes 001111 (increment) and 001011 (decrement) produce their arithmetic result. None of the three changes any flag.
- R8: Word 0000 001f ffff writes W to the file register with flags unchanged. Word 0000 011f ffff writes zero to the file register and sets Z. Word 0x040 writes zero to W and sets Z.
- R9: Top nibble 0100 clears and 0101 sets bit [7:5] of the file value and writes it back, with flags unchanged. Top nibbles 0110 and 0111 (bit tests) write nothing and change no flag.
- R10: Top nibbles 1100, 1101, 1110 and 1111 respectively load, OR, AND and XOR the literal in bits [7:0] into W. The load leaves all flags unchanged, and the other three update Z only.
- R11: Every other word, including 0x000–0x03F with bit 5 clear except 0x040, words 0x041–0x05F, and top nibbles 1000–1011, raises no strobe, gives result zero and passes all flags through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 12 | Instruction word |
| w_in | input | 8 | Working register value |
| f_in | input | 8 | Addressed file-register value |
| c_in | input | 1 | Incoming carry flag |
| dc_in | input | 1 | Incoming digit-carry flag |
| z_in | input | 1 | Incoming zero flag |
| result | output | 8 | Registered result value |
| w_we | output | 1 | Write result to W |
| f_we | output | 1 | Write result to file register |
| f_addr | output | 5 | Registered file address |
| c_out | output | 1 | Next carry flag |
| dc_out | output | 1 | Next digit-carry flag |
| z_out | output | 1 | Next zero flag |

## Verification
The properties assume that every input is a known value at each rising edge. They also assume that the result seen one edge later belongs to the word sampled at the edge before, so a check is enabled only once a full cycle has passed outside reset. The bench drives each new word and operand set on the falling edge. It holds them across exactly one rising edge and reads the outputs at the next falling edge, so each sample maps to one instruction and never to a mixture of two.

// File: rtl/base12_alu.sv
module base12_alu #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [11:0]   instr,
  input  logic [DW-1:0] w_in,
  input  logic [DW-1:0] f_in,
  input  logic          c_in,
  input  logic          dc_in,
  input  logic          z_in,
  output logic [DW-1:0] result,
  output logic          w_we,
  output logic          f_we,
  output logic [AW-1:0] f_addr,
  output logic          c_out,
  output logic          dc_out,
  output logic          z_out
);
  localparam int HW = DW / 2;
  localparam int BW = $clog2(DW);

  logic [5:0]    op6;
  logic          dst;
  logic [AW-1:0] fa;
  logic [DW-1:0] lit;
  logic [BW-1:0] bsel;
  logic [DW-1:0] bmask;

  assign op6   = instr[11:6];
  assign dst   = instr[5];
  assign fa    = instr[AW-1:0];
  assign lit   = instr[DW-1:0];
  assign bsel  = instr[7:5];
  assign bmask = DW'(1) << bsel;

  logic [DW:0] add_s, sub_s;
  logic [HW:0] add_n, sub_n;

  assign add_s = {1'b0, f_in} + {1'b0, w_in};
  assign add_n = {1'b0, f_in[HW-1:0]} + {1'b0, w_in[HW-1:0]};
  assign sub_s = {1'b0, f_in} + {1'b0, ~w_in} + (DW+1)'(1);
  assign sub_n = {1'b0, f_in[HW-1:0]} + {1'b0, ~w_in[HW-1:0]} + (HW+1)'(1);

  logic [DW-1:0] r;
  logic          wr_d, wr_w, wr_f, set_z;
  logic          nc, ndc;

  always_comb begin
    r     = '0;
    wr_d  = 1'b0;
    wr_w  = 1'b0;
    wr_f  = 1'b0;
    set_z = 1'b0;
    nc    = c_in;
    ndc   = dc_in;
    case (instr[11:10])
      2'b00: begin
        case (op6)
          6'b000000: if (dst) begin r = w_in; wr_f = 1'b1; end
          6'b000001: begin
            if (dst) begin
              wr_f = 1'b1; set_z = 1'b1;
            end else if (fa == '0) begin
              wr_w = 1'b1; set_z = 1'b1;
            end
          end
          6'b000010: begin
            r = sub_s[DW-1:0]; nc = sub_s[DW]; ndc = sub_n[HW];
            wr_d = 1'b1; set_z = 1'b1;
          end
          6'b000011: begin r = f_in - DW'(1); wr_d = 1'b1; set_z = 1'b1; end
          6'b000100: begin r = w_in | f_in;   wr_d = 1'b1; set_z = 1'b1; end
          6'b000101: begin r = w_in & f_in;   wr_d = 1'b1; set_z = 1'b1; end
          6'b000110: begin r = w_in ^ f_in;   wr_d = 1'b1; set_z = 1'b1; end
          6'b000111: begin
            r = add_s[DW-1:0]; nc = add_s[DW]; ndc = add_n[HW];
            wr_d = 1'b1; set_z = 1'b1;
          end
          6'b001000: begin r = f_in;          wr_d = 1'b1; set_z = 1'b1; end
          6'b001001: begin r = ~f_in;         wr_d = 1'b1; set_z = 1'b1; end
          6'b001010: begin r = f_in + DW'(1); wr_d = 1'b1; set_z = 1'b1; end
          6'b001011: begin r = f_in - DW'(1); wr_d = 1'b1; end
          6'b001100: begin r = {c_in, f_in[DW-1:1]}; nc = f_in[0];    wr_d = 1'b1; end
          6'b001101: begin r = {f_in[DW-2:0], c_in}; nc = f_in[DW-1]; wr_d = 1'b1; end
          6'b001110: begin r = {f_in[HW-1:0], f_in[DW-1:HW]}; wr_d = 1'b1; end
          6'b001111: begin r = f_in + DW'(1); wr_d = 1'b1; end
          default: ;
        endcase
      end
      2'b01: begin
        case (instr[9:8])
          2'b00: begin r = f_in & ~bmask; wr_f = 1'b1; end
          2'b01: begin r = f_in | bmask;  wr_f = 1'b1; end
          default: ;
        endcase
      end
      2'b11: begin
        wr_w = 1'b1;
        case (instr[9:8])
          2'b00: r = lit;
          2'b01: begin r = w_in | lit; set_z = 1'b1; end
          2'b10: begin r = w_in & lit; set_z = 1'b1; end
          default: begin r = w_in ^ lit; set_z = 1'b1; end
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      w_we   <= 1'b0;
      f_we   <= 1'b0;
      f_addr <= '0;
      c_out  <= 1'b0;
      dc_out <= 1'b0;
      z_out  <= 1'b0;
    end else begin
      result <= r;
      w_we   <= wr_w | (wr_d & ~dst);
      f_we   <= wr_f | (wr_d & dst);
      f_addr <= fa;
      c_out  <= nc;
      dc_out <= ndc;
      z_out  <= set_z ? (r == '0) : z_in;
    end
  end
endmodule

// File: rtl/base12_alu_chk.sv
module base12_alu_chk #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [11:0]   instr,
  input logic [DW-1:0] w_in,
  input logic [DW-1:0] f_in,
  input logic          c_in,
  input logic          dc_in,
  input logic          z_in,
  input logic [DW-1:0] result,
  input logic          w_we,
  input logic          f_we,
  input logic [AW-1:0] f_addr,
  input logic          c_out,
  input logic          dc_out,
  input logic          z_out
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_one_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_we && f_we));

  assert_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> f_addr == $past(instr[AW-1:0]));

  assert_add_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(instr[11:6]) == 6'b000111)
      |-> {c_out, result} == ({1'b0, $past(w_in)} + {1'b0, $past(f_in)}));

  assert_sub_borrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(instr[11:6]) == 6'b000010)
      |-> c_out == ($past(f_in) >= $past(w_in)));

  assert_zero_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(instr[11:6]) inside {6'b000011, 6'b000100, 6'b000101,
                                         6'b000110, 6'b001000, 6'b001001, 6'b001010})
      |-> (z_out == (result == '0)) && c_out == $past(c_in) && dc_out == $past(dc_in));

  assert_bit_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(instr[11:9]) == 3'b010)
      |-> f_we && !w_we && c_out == $past(c_in) && dc_out == $past(dc_in)
          && z_out == $past(z_in));

  assert_lit_dest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(instr[11:10]) == 2'b11) |-> w_we && !f_we);

  assert_movlw_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(instr[11:8]) == 4'b1100)
      |-> result == $past(instr[7:0]) && z_out == $past(z_in) && c_out == $past(c_in));

  assert_ctrl_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(instr[11:10]) == 2'b10)
      |-> !w_we && !f_we && c_out == $past(c_in) && dc_out == $past(dc_in)
          && z_out == $past(z_in));
endmodule

bind base12_alu base12_alu_chk u_chk (.*);

// File: tb/base12_alu_tb.sv
`timescale 1ns/1ps
module base12_alu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [11:0] instr = '0;
  logic [7:0] w_in = '0, f_in = '0;
  logic       c_in = 1'b0, dc_in = 1'b0, z_in = 1'b0;
  logic [7:0] result;
  logic       w_we, f_we, c_out, dc_out, z_out;
  logic [4:0] f_addr;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  base12_alu u_dut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .w_in(w_in), .f_in(f_in),
    .c_in(c_in), .dc_in(dc_in), .z_in(z_in), .result(result), .w_we(w_we),
    .f_we(f_we), .f_addr(f_addr), .c_out(c_out), .dc_out(dc_out), .z_out(z_out)
  );

  // {req, instr, w, f, c/dc/z in, exp result, exp w_we, exp f_we, exp c/dc/z}
  localparam int NV = 38;
  localparam logic [47:0] VEC [NV] = '{
    {4'd3,  12'h1E5, 8'h0F, 8'h01, 3'b000, 8'h10, 1'b0, 1'b1, 3'b010}, // R3 digit carry, d=1
    {4'd3,  12'h1C5, 8'h80, 8'h80, 3'b000, 8'h00, 1'b1, 1'b0, 3'b101}, // R3 carry, zero
    {4'd3,  12'h1C5, 8'hFF, 8'h01, 3'b000, 8'h00, 1'b1, 1'b0, 3'b111}, // R3 all flags
    {4'd4,  12'h083, 8'h03, 8'h05, 3'b000, 8'h02, 1'b1, 1'b0, 3'b110}, // R4 no borrow
    {4'd4,  12'h0A3, 8'h05, 8'h03, 3'b111, 8'hFE, 1'b0, 1'b1, 3'b000}, // R4 borrow
    {4'd4,  12'h083, 8'h01, 8'h10, 3'b000, 8'h0F, 1'b1, 1'b0, 3'b100}, // R4 nibble borrow
    {4'd4,  12'h083, 8'h42, 8'h42, 3'b000, 8'h00, 1'b1, 1'b0, 3'b111}, // R4 equal
    {4'd5,  12'h141, 8'hF0, 8'h0F, 3'b110, 8'h00, 1'b1, 1'b0, 3'b111}, // R5 AND
    {4'd5,  12'h122, 8'h0A, 8'h50, 3'b001, 8'h5A, 1'b0, 1'b1, 3'b000}, // R5 OR
    {4'd5,  12'h180, 8'hAA, 8'hAA, 3'b110, 8'h00, 1'b1, 1'b0, 3'b111}, // R5 XOR
    {4'd5,  12'h267, 8'h12, 8'hFF, 3'b000, 8'h00, 1'b0, 1'b1, 3'b001}, // R5 complement
    {4'd5,  12'h281, 8'h00, 8'hFF, 3'b100, 8'h00, 1'b1, 1'b0, 3'b101}, // R5 increment wraps, C kept
    {4'd5,  12'h0E1, 8'h00, 8'h01, 3'b000, 8'h00, 1'b0, 1'b1, 3'b001}, // R5 decrement
    {4'd5,  12'h204, 8'h55, 8'h00, 3'b000, 8'h00, 1'b1, 1'b0, 3'b001}, // R5 move zero
    {4'd5,  12'h204, 8'h55, 8'h80, 3'b001, 8'h80, 1'b1, 1'b0, 3'b000}, // R5 move nonzero
    {4'd6,  12'h362, 8'h00, 8'h81, 3'b011, 8'h02, 1'b0, 1'b1, 3'b111}, // R6 rotate left
    {4'd6,  12'h302, 8'h00, 8'h02, 3'b100, 8'h81, 1'b1, 1'b0, 3'b000}, // R6 rotate right
    {4'd7,  12'h3A3, 8'h00, 8'h3C, 3'b101, 8'hC3, 1'b0, 1'b1, 3'b101}, // R7 swap
    {4'd7,  12'h3C0, 8'h00, 8'hFF, 3'b000, 8'h00, 1'b1, 1'b0, 3'b000}, // R7 inc, Z untouched
    {4'd7,  12'h2E1, 8'h00, 8'h01, 3'b000, 8'h00, 1'b0, 1'b1, 3'b000}, // R7 dec, Z untouched
    {4'd8,  12'h026, 8'h9C, 8'h11, 3'b010, 8'h9C, 1'b0, 1'b1, 3'b010}, // R8 W to file
    {4'd8,  12'h065, 8'h00, 8'h77, 3'b100, 8'h00, 1'b0, 1'b1, 3'b101}, // R8 clear file
    {4'd8,  12'h040, 8'h33, 8'h00, 3'b010, 8'h00, 1'b1, 1'b0, 3'b011}, // R8 clear W
    {4'd9,  12'h4E1, 8'h00, 8'hFF, 3'b000, 8'h7F, 1'b0, 1'b1, 3'b000}, // R9 clear bit 7
    {4'd9,  12'h502, 8'h00, 8'h00, 3'b111, 8'h01, 1'b0, 1'b1, 3'b111}, // R9 set bit 0
    {4'd9,  12'h560, 8'h00, 8'hF0, 3'b001, 8'hF8, 1'b0, 1'b1, 3'b001}, // R9 set bit 3
    {4'd9,  12'h600, 8'h00, 8'h01, 3'b000, 8'h00, 1'b0, 1'b0, 3'b000}, // R9 test clear
    {4'd9,  12'h7FF, 8'hFF, 8'hFF, 3'b101, 8'h00, 1'b0, 1'b0, 3'b101}, // R9 test set
    {4'd10, 12'hC00, 8'h12, 8'h00, 3'b000, 8'h00, 1'b1, 1'b0, 3'b000}, // R10 load zero, Z kept
    {4'd10, 12'hCA5, 8'h12, 8'h00, 3'b011, 8'hA5, 1'b1, 1'b0, 3'b011}, // R10 load
    {4'd10, 12'hD00, 8'h00, 8'h00, 3'b100, 8'h00, 1'b1, 1'b0, 3'b101}, // R10 OR literal
    {4'd10, 12'hE0F, 8'hF3, 8'h00, 3'b001, 8'h03, 1'b1, 1'b0, 3'b000}, // R10 AND literal
    {4'd10, 12'hFFF, 8'h0F, 8'h00, 3'b000, 8'hF0, 1'b1, 1'b0, 3'b000}, // R10 XOR literal
    {4'd11, 12'h000, 8'h44, 8'h44, 3'b111, 8'h00, 1'b0, 1'b0, 3'b111}, // R11 no-op
    {4'd11, 12'h004, 8'h44, 8'h44, 3'b010, 8'h00, 1'b0, 1'b0, 3'b010}, // R11 system word
    {4'd11, 12'hA12, 8'h44, 8'h44, 3'b101, 8'h00, 1'b0, 1'b0, 3'b101}, // R11 branch
    {4'd11, 12'h8AA, 8'h44, 8'h44, 3'b110, 8'h00, 1'b0, 1'b0, 3'b110}, // R11 return word
    {4'd11, 12'h041, 8'h44, 8'h44, 3'b000, 8'h00, 1'b0, 1'b0, 3'b000}  // R11 stray clear word
  };

  task automatic check(input string tag, input logic [14:0] act, input logic [14:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    instr = 12'hFFF; w_in = 8'hFF; f_in = 8'hFF; {c_in, dc_in, z_in} = 3'b111;
    repeat (3) @(negedge clk);
    // R1 outputs held at zero during reset
    check("R1", {result, w_we, f_we, c_out, dc_out, z_out, 2'b00}, 15'h0);
    tests++;
    if (f_addr !== 5'd0) begin fails++; $display("FAIL R1 addr: got %h expected 00", f_addr); end
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      instr = VEC[i][43:32];
      w_in  = VEC[i][31:24];
      f_in  = VEC[i][23:16];
      {c_in, dc_in, z_in} = VEC[i][15:13];
      @(negedge clk);
      check($sformatf("R%0d vec %0d", VEC[i][47:44], i),
            {result, w_we, f_we, c_out, dc_out, z_out, 2'b00},
            {VEC[i][12:0], 2'b00});
      // R2 registered address follows bits [4:0]
      tests++;
      if (f_addr !== VEC[i][36:32]) begin
        fails++;
        $display("FAIL R2 addr vec %0d: got %h expected %h", i, f_addr, VEC[i][36:32]);
      end
    end

    // R2 back-to-back words: each output belongs to the previous edge
    @(negedge clk);
    instr = 12'h1C5; w_in = 8'h01; f_in = 8'h02; {c_in, dc_in, z_in} = 3'b000;
    @(negedge clk);
    instr = 12'h1E5;
    check("R2 pipe d=0", {result, w_we, f_we, c_out, dc_out, z_out, 2'b00},
          {8'h03, 1'b1, 1'b0, 3'b000, 2'b00});
    @(negedge clk);
    check("R2 pipe d=1", {result, w_we, f_we, c_out, dc_out, z_out, 2'b00},
          {8'h03, 1'b0, 1'b1, 3'b000, 2'b00});

    // R1 reset in mid-run clears a pending write
    instr = 12'h026; w_in = 8'h5A; {c_in, dc_in, z_in} = 3'b111;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid-run", {result, w_we, f_we, c_out, dc_out, z_out, 2'b00}, 15'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after reset", {result, w_we, f_we, c_out, dc_out, z_out, 2'b00},
          {8'h5A, 1'b0, 1'b1, 3'b111, 2'b00});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule